// File: doc/BRIEF.md
# Board System Control Port Bank

This block is a bank of 8-bit control and status ports that sits on a simple single-cycle I/O port bus. A host selects a port with an address and then pulses a read or a write strobe. The bank holds a handful of board control bits and drives each one out as a level: a soft-reset request, a little-endian byte-order mode, a disk-activity lamp, an I/O map-type flag that steers address translation elsewhere, and a 4-bit system control field. Two non-volatile-memory lock toggles leave the block as one-cycle pulses.

The bank decodes one isolated port for reset and byte order, and a contiguous window of board ports. The window holds fixed identification and status bytes, the writable control ports, and unassigned addresses. A chip-select output marks every address that the bank owns, so other decoders on the bus can ignore it. Read data is combinational and valid while the read strobe is high. A write takes effect at the clock edge that samples the write strobe.

Top module: `sysctl_bank`

## Requirements
- R1: A write to port 0x092 sets `soft_rst` to data bit 0 and `le_mode` to data bit 1 after the sampling edge. Both keep their level until the next write to 0x092.
- R2: A read of port 0x092 returns 0x00, whatever `soft_rst` and `le_mode` hold.
- R3: Reads return fixed bytes at these ports: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, and 0x823 gives 0x03. A write to any of 0x800, 0x802 or 0x803 changes no output and no later read value.
- R4: A write to port 0x808 sets `disk_led` to data bit 0.
- R5: A write to port 0x81C stores data bits 3:0 on `sys_ctl`. A read of 0x81C returns {4'b0, stored field}.
- R6: A write to port 0x850 stores data bit 0 on `map_noncontig` (1 = non-contiguous). A read of 0x850 returns {7'b0, flag}.
- R7: A write to 0x810 raises `lock1_pulse`, and a write to 0x812 raises `lock2_pulse`. Each pulse is high for exactly the one cycle after the sampling edge.
- R8: A read of 0x818 returns 0x00. A read of any other window address with no assignment returns 0xFF. A write to such an address changes nothing.
- R9: `port_sel` is 1 only for address 0x092 and for 0x800 through 0x851. Outside these, a read gives `port_rdata` = 0x00 and a write changes nothing. `port_rdata` is also 0x00 whenever `port_rd` is low.
- R10: A synchronous active-low reset clears every stored bit and both pulses to 0.
- R11: When read and write strobes are high in the same cycle at the same port, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_addr | input | 16 | Port address |
| port_wdata | input | 8 | Write data |
| port_rd | input | 1 | Read strobe |
| port_wr | input | 1 | Write strobe |
| port_rdata | output | 8 | Read data, combinational |
| port_sel | output | 1 | Address belongs to this bank |
| soft_rst | output | 1 | Soft-reset request level |
| le_mode | output | 1 | Little-endian byte-order mode |
| disk_led | output | 1 | Disk-activity indicator |
| map_noncontig | output | 1 | I/O map type, 1 = non-contiguous |
| sys_ctl | output | 4 | System control field |
| lock1_pulse | output | 1 | First lock toggle pulse |
| lock2_pulse | output | 1 | Second lock toggle pulse |

## Verification
Two functions can fall in the same cycle: a read of a writable port and a write to that same port. The bench provokes this by raising both strobes in one cycle at 0x81C, 0x850 and 0x810. It then judges two things. The read data must show the value held before the write, and after the edge the outputs must show the new value, or the lock pulse for 0x810. The random traffic also lands such paired strobes on arbitrary addresses, and a reference model predicts both halves.

// File: rtl/sysctl_pkg.sv
// Package: shared port kinds, window placement and fixed byte values.
// Assumes a 16-bit port address space; offsets are relative to the window base.
package sysctl_pkg;

    typedef enum logic [3:0] {
        K_NONE,     // not owned by the bank
        K_RSTEND,   // reset / byte-order port
        K_ID_CPU,
        K_ID_FEAT,
        K_ID_STAT,
        K_EQUIP,
        K_LOCK1,    // reads extended-feature byte, writes toggle lock 1
        K_LOCK2,
        K_KEYLOCK,
        K_SYSCTL,
        K_CACHE,
        K_MAPTYPE,
        K_DISK,
        K_UNUSED    // inside window, unassigned
    } port_kind_e;

    localparam int unsigned OFS_ID_CPU  = 'h00;
    localparam int unsigned OFS_ID_FEAT = 'h02;
    localparam int unsigned OFS_ID_STAT = 'h03;
    localparam int unsigned OFS_DISK    = 'h08;
    localparam int unsigned OFS_EQUIP   = 'h0C;
    localparam int unsigned OFS_LOCK1   = 'h10;
    localparam int unsigned OFS_LOCK2   = 'h12;
    localparam int unsigned OFS_KEYLOCK = 'h18;
    localparam int unsigned OFS_SYSCTL  = 'h1C;
    localparam int unsigned OFS_CACHE   = 'h23;
    localparam int unsigned OFS_MAPTYPE = 'h50;

    localparam logic [7:0] VAL_ID_CPU  = 8'hEF;
    localparam logic [7:0] VAL_ID_FEAT = 8'hAD;
    localparam logic [7:0] VAL_ID_STAT = 8'hE0;
    localparam logic [7:0] VAL_EQUIP   = 8'h3C;
    localparam logic [7:0] VAL_EXTFEAT = 8'h39;
    localparam logic [7:0] VAL_CACHE   = 8'h03;
    localparam logic [7:0] VAL_UNUSED  = 8'hFF;

endpackage

// File: rtl/sysctl_decode.sv
// Module: address decoder. Classifies a port address into a port kind and
// raises the select for every address the bank owns.
// Assumes WIN_LAST >= WIN_BASE and that RSTEND_PORT lies outside the window.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned RSTEND_PORT = 'h092,
    parameter int unsigned WIN_BASE    = 'h800,
    parameter int unsigned WIN_LAST    = 'h851
) (
    input  logic [ADDR_W-1:0] addr,
    output port_kind_e        kind,
    output logic              sel
);
    localparam logic [ADDR_W-1:0] RSTEND_A = ADDR_W'(RSTEND_PORT);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] LAST_A   = ADDR_W'(WIN_LAST);

    logic              in_win;
    logic [ADDR_W-1:0] ofs;

    // Window membership and offset inside it.
    always_comb begin
        in_win = (addr >= BASE_A) && (addr <= LAST_A);
        ofs    = addr - BASE_A;
    end

    // Map the address to a port kind.
    always_comb begin
        kind = K_NONE;
        if (addr == RSTEND_A) begin
            kind = K_RSTEND;
        end else if (in_win) begin
            case (ofs)
                ADDR_W'(OFS_ID_CPU):  kind = K_ID_CPU;
                ADDR_W'(OFS_ID_FEAT): kind = K_ID_FEAT;
                ADDR_W'(OFS_ID_STAT): kind = K_ID_STAT;
                ADDR_W'(OFS_DISK):    kind = K_DISK;
                ADDR_W'(OFS_EQUIP):   kind = K_EQUIP;
                ADDR_W'(OFS_LOCK1):   kind = K_LOCK1;
                ADDR_W'(OFS_LOCK2):   kind = K_LOCK2;
                ADDR_W'(OFS_KEYLOCK): kind = K_KEYLOCK;
                ADDR_W'(OFS_SYSCTL):  kind = K_SYSCTL;
                ADDR_W'(OFS_CACHE):   kind = K_CACHE;
                ADDR_W'(OFS_MAPTYPE): kind = K_MAPTYPE;
                default:              kind = K_UNUSED;
            endcase
        end
    end

    // Select covers the isolated port and the whole window.
    always_comb sel = (kind != K_NONE);

endmodule

// File: rtl/sysctl_regs.sv
// Module: stored control state and lock pulses. Updates on a write strobe
// according to the decoded kind; all state clears on synchronous reset.
// Assumes kind is already qualified by the decoder (K_NONE outside the bank).
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CTL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  port_kind_e        kind,
    input  logic [DATA_W-1:0] wdata,
    output logic              soft_rst,
    output logic              le_mode,
    output logic              disk_led,
    output logic              map_noncontig,
    output logic [CTL_W-1:0]  sys_ctl,
    output logic              lock1_pulse,
    output logic              lock2_pulse
);
    logic wr_rstend, wr_disk, wr_sysctl, wr_map;

    // Per-port write enables.
    always_comb begin
        wr_rstend = wr && (kind == K_RSTEND);
        wr_disk   = wr && (kind == K_DISK);
        wr_sysctl = wr && (kind == K_SYSCTL);
        wr_map    = wr && (kind == K_MAPTYPE);
    end

    // Level registers written by their own ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_rst      <= 1'b0;
            le_mode       <= 1'b0;
            disk_led      <= 1'b0;
            map_noncontig <= 1'b0;
            sys_ctl       <= '0;
        end else begin
            if (wr_rstend) begin
                soft_rst <= wdata[0];
                le_mode  <= wdata[1];
            end
            if (wr_disk)   disk_led      <= wdata[0];
            if (wr_sysctl) sys_ctl       <= wdata[CTL_W-1:0];
            if (wr_map)    map_noncontig <= wdata[0];
        end
    end

    // One-cycle lock toggle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock1_pulse <= 1'b0;
            lock2_pulse <= 1'b0;
        end else begin
            lock1_pulse <= wr && (kind == K_LOCK1);
            lock2_pulse <= wr && (kind == K_LOCK2);
        end
    end

    assert_rstend_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rstend |=> ($stable(soft_rst) && $stable(le_mode)));
    assert_disk_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_disk |=> $stable(disk_led));
    assert_sysctl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sysctl |=> $stable(sys_ctl));
    assert_map_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_map |=> $stable(map_noncontig));
    assert_lock_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock1_pulse |-> $past(wr && kind == K_LOCK1));
    assert_lock_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lock1_pulse, lock2_pulse}));
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!soft_rst && !le_mode && !lock1_pulse && !lock2_pulse));

endmodule

// File: rtl/sysctl_rdmux.sv
// Module: read data mux. Returns the byte for the decoded kind while the read
// strobe is high, zero otherwise. Purely combinational.
module sysctl_rdmux
    import sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CTL_W  = 4
) (
    input  logic              rd,
    input  port_kind_e        kind,
    input  logic              map_noncontig,
    input  logic [CTL_W-1:0]  sys_ctl,
    output logic [DATA_W-1:0] rdata
);
    // Select the returned byte.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (kind)
                K_ID_CPU:  rdata = VAL_ID_CPU;
                K_ID_FEAT: rdata = VAL_ID_FEAT;
                K_ID_STAT: rdata = VAL_ID_STAT;
                K_EQUIP:   rdata = VAL_EQUIP;
                K_LOCK1:   rdata = VAL_EXTFEAT;
                K_CACHE:   rdata = VAL_CACHE;
                K_SYSCTL:  rdata = DATA_W'(sys_ctl);
                K_MAPTYPE: rdata = DATA_W'(map_noncontig);
                K_LOCK2, K_DISK, K_UNUSED: rdata = VAL_UNUSED;
                default:   rdata = '0;   // reset/endian, keylock, not owned
            endcase
        end
    end
endmodule

// File: rtl/sysctl_bank.sv
// Module: top of the system control port bank. Wires decoder, state and read
// mux. Assumes a single-cycle port bus: strobes are sampled on one clock edge.
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CTL_W       = 4,
    parameter int unsigned RSTEND_PORT = 'h092,
    parameter int unsigned WIN_BASE    = 'h800,
    parameter int unsigned WIN_LAST    = 'h851
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [DATA_W-1:0] port_wdata,
    input  logic              port_rd,
    input  logic              port_wr,
    output logic [DATA_W-1:0] port_rdata,
    output logic              port_sel,
    output logic              soft_rst,
    output logic              le_mode,
    output logic              disk_led,
    output logic              map_noncontig,
    output logic [CTL_W-1:0]  sys_ctl,
    output logic              lock1_pulse,
    output logic              lock2_pulse
);
    port_kind_e kind;

    sysctl_decode #(
        .ADDR_W(ADDR_W), .RSTEND_PORT(RSTEND_PORT),
        .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)
    ) u_decode (
        .addr(port_addr), .kind(kind), .sel(port_sel)
    );

    sysctl_regs #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(port_wr), .kind(kind),
        .wdata(port_wdata), .soft_rst(soft_rst), .le_mode(le_mode),
        .disk_led(disk_led), .map_noncontig(map_noncontig),
        .sys_ctl(sys_ctl), .lock1_pulse(lock1_pulse),
        .lock2_pulse(lock2_pulse)
    );

    sysctl_rdmux #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_rdmux (
        .rd(port_rd), .kind(kind), .map_noncontig(map_noncontig),
        .sys_ctl(sys_ctl), .rdata(port_rdata)
    );

    assert_unowned_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !port_sel) |=> ($stable(soft_rst) && $stable(sys_ctl)
                                   && $stable(map_noncontig) && !lock1_pulse));
    assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !port_rd |-> (port_rdata == '0));

endmodule

// File: tb/test_sysctl_bank.sv
`timescale 1ns/1ps
module test_sysctl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] port_addr = '0;
    logic [7:0]  port_wdata = '0;
    logic        port_rd = 1'b0;
    logic        port_wr = 1'b0;
    logic [7:0]  port_rdata;
    logic        port_sel;
    logic        soft_rst, le_mode, disk_led, map_noncontig;
    logic [3:0]  sys_ctl;
    logic        lock1_pulse, lock2_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    bit       m_soft, m_le, m_disk, m_map;
    bit [3:0] m_ctl;

    always #4 clk = ~clk;

    sysctl_bank i_sysctl_bank (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_rd(port_rd), .port_wr(port_wr),
        .port_rdata(port_rdata), .port_sel(port_sel), .soft_rst(soft_rst),
        .le_mode(le_mode), .disk_led(disk_led),
        .map_noncontig(map_noncontig), .sys_ctl(sys_ctl),
        .lock1_pulse(lock1_pulse), .lock2_pulse(lock2_pulse)
    );

    function automatic bit owned(input logic [15:0] a);
        return (a == 16'h092) || (a >= 16'h800 && a <= 16'h851);
    endfunction

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        if (!owned(a)) return 8'h00;
        case (a)
            16'h092: return 8'h00;
            16'h800: return 8'hEF;
            16'h802: return 8'hAD;
            16'h803: return 8'hE0;
            16'h80C: return 8'h3C;
            16'h810: return 8'h39;
            16'h823: return 8'h03;
            16'h818: return 8'h00;
            16'h81C: return {4'h0, m_ctl};
            16'h850: return {7'h0, m_map};
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        case (a)
            16'h092: begin m_soft = d[0]; m_le = d[1]; end
            16'h808: m_disk = d[0];
            16'h81C: m_ctl = d[3:0];
            16'h850: m_map = d[0];
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic chk_outputs(input string req, input bit exp_l1, input bit exp_l2);
        chk({req, " soft_rst R1"}, 32'(soft_rst), 32'(m_soft));
        chk({req, " le_mode R1"}, 32'(le_mode), 32'(m_le));
        chk({req, " disk_led R4"}, 32'(disk_led), 32'(m_disk));
        chk({req, " sys_ctl R5"}, 32'(sys_ctl), 32'(m_ctl));
        chk({req, " map R6"}, 32'(map_noncontig), 32'(m_map));
        chk({req, " lock1 R7"}, 32'(lock1_pulse), 32'(exp_l1));
        chk({req, " lock2 R7"}, 32'(lock2_pulse), 32'(exp_l2));
    endtask

    // One bus cycle; rd and/or wr; read checked before the edge (R11 when both).
    task automatic bus_op(input logic [15:0] a, input logic [7:0] d,
                          input bit rd, input bit wr, input string req);
        logic [7:0] exp_r;
        exp_r = exp_read(a);
        port_addr = a; port_wdata = d; port_rd = rd; port_wr = wr;
        #1;
        chk({req, " sel R9"}, 32'(port_sel), 32'(owned(a)));
        chk({req, " rdata R2 R3 R8 R9 R11"}, 32'(port_rdata), rd ? 32'(exp_r) : 32'h0);
        if (wr) model_write(a, d);
        @(negedge clk);
        port_rd = 1'b0; port_wr = 1'b0;
        chk_outputs(req, wr && a == 16'h810, wr && a == 16'h812);
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        chk_outputs(req, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_soft = 0; m_le = 0; m_disk = 0; m_map = 0; m_ctl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk_outputs("reset R10", 1'b0, 1'b0);

        // Directed: R1 and R2
        bus_op(16'h092, 8'h03, 0, 1, "R1 set both");
        bus_op(16'h092, 8'h00, 1, 0, "R2 read zero");
        idle_check("R1 hold");
        bus_op(16'h092, 8'hFE, 0, 1, "R1 endian only");
        // R3 fixed bytes and ignored writes
        bus_op(16'h800, 8'h00, 1, 0, "R3 cpu");
        bus_op(16'h802, 8'h00, 1, 0, "R3 feat");
        bus_op(16'h803, 8'h00, 1, 0, "R3 stat");
        bus_op(16'h80C, 8'h00, 1, 0, "R3 equip");
        bus_op(16'h823, 8'h00, 1, 0, "R3 cache");
        bus_op(16'h800, 8'h12, 0, 1, "R3 write ignored");
        bus_op(16'h802, 8'h55, 0, 1, "R3 write ignored");
        bus_op(16'h803, 8'hFF, 0, 1, "R3 write ignored");
        bus_op(16'h800, 8'h00, 1, 0, "R3 cpu after write");
        // R4
        bus_op(16'h808, 8'hF1, 0, 1, "R4 led on");
        bus_op(16'h808, 8'h0E, 0, 1, "R4 led off");
        // R5
        bus_op(16'h81C, 8'hA7, 0, 1, "R5 low nibble");
        bus_op(16'h81C, 8'h00, 1, 0, "R5 readback");
        // R6
        bus_op(16'h850, 8'hFF, 0, 1, "R6 noncontig");
        bus_op(16'h850, 8'h00, 1, 0, "R6 readback");
        // R7 pulses, back to back, then idle
        bus_op(16'h810, 8'h00, 0, 1, "R7 lock1");
        bus_op(16'h812, 8'h00, 0, 1, "R7 lock2");
        idle_check("R7 pulse ends");
        bus_op(16'h810, 8'h00, 1, 0, "R3 extfeat");
        // R8
        bus_op(16'h818, 8'h00, 1, 0, "R8 keylock");
        bus_op(16'h801, 8'h00, 1, 0, "R8 unassigned");
        bus_op(16'h851, 8'h5A, 0, 1, "R8 unassigned write");
        bus_op(16'h814, 8'h00, 1, 0, "R8 unassigned");
        // R9 boundaries
        bus_op(16'h852, 8'hFF, 1, 1, "R9 above window");
        bus_op(16'h7FF, 8'hFF, 1, 1, "R9 below window");
        bus_op(16'h093, 8'hFF, 1, 1, "R9 near special");
        bus_op(16'h851, 8'h00, 1, 0, "R9 last in window");
        // R11 simultaneous read and write
        bus_op(16'h81C, 8'h05, 1, 1, "R11 sysctl");
        bus_op(16'h850, 8'h00, 1, 1, "R11 map");
        bus_op(16'h810, 8'h00, 1, 1, "R11 lock1");
        bus_op(16'h092, 8'h01, 1, 1, "R11 special");

        // Constrained random traffic
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            int pick;
            bit r, w;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1, 2, 3: a = 16'h800 + 16'($urandom_range(0, 'h51));
                4:          a = 16'h092;
                5:          a = 16'($urandom());
                6:          a = 16'h81C;
                7:          a = 16'h850;
                8:          a = ($urandom_range(0, 1) != 0) ? 16'h810 : 16'h812;
                default:    a = 16'h808;
            endcase
            r = $urandom_range(0, 1) != 0;
            w = $urandom_range(0, 2) != 0;
            bus_op(a, 8'($urandom()), r, w, "random");
        end

        // R10 reset in mid-operation
        bus_op(16'h092, 8'h03, 0, 1, "pre-reset");
        bus_op(16'h81C, 8'h0F, 0, 1, "pre-reset");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_soft = 0; m_le = 0; m_disk = 0; m_map = 0; m_ctl = 0;
        chk_outputs("reset again R10", 1'b0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule